// File: doc/BRIEF.md
# Video and Sound Controller Register Bank

This block is the write-only configuration store of a raster video and sound controller. The host issues single-cycle 32-bit writes as a strobe plus a data word. The top six data bits name the target register and the lower bits carry the value, so no separate address bus exists. Behind this decode sit 16 palette colours, a border colour, three cursor colours, two sets of eight raster timing values, a control word, eight stereo positions and a sound frequency.

Every stored value is presented continuously on parallel outputs. A timing generator reads the timing values, the pixel pipeline reads the colours, and the audio path reads the stereo and frequency settings. The two low bits of the control word choose the pixel rate. A write to a select that no register answers changes no state and raises a one-cycle error pulse.

Top module: `vctl_regbank`

## Requirements
- R1: A synchronous reset clears every stored value and the error flag to zero, except the control word, which resets to 3 so that the pixel rate (control bits [1:0]) starts at its fastest setting, 2'b11.
- R2: The register code is `wr_data[31:26]` (select byte `wr_data[31:24]` with bits [25:24] ignored), so a write whose bits [25:24] are set reaches the same register as one where they are clear.
- R3: Codes 0 to 15 (select bytes 0x00 to 0x3C) store `wr_data[12:0]` into palette entry equal to the code.
- R4: Code 16 (select 0x40) stores `wr_data[12:0]` as the border colour. Codes 17, 18 and 19 (selects 0x44, 0x48, 0x4C) store it as cursor colours 0, 1 and 2.
- R5: Codes 32 to 39 (selects 0x80 to 0x9C) store `wr_data[23:14]` into horizontal slot code-32. The slots in order are period, sync width, border start, display start, display end, border end, cursor end and interlace.
- R6: Codes 40 to 47 (selects 0xA0 to 0xBC) store `wr_data[23:14]` into vertical slot code-40. The slots in order are period, sync width, border start, display start, display end, border end, cursor start and cursor end.
- R7: Codes 24 to 31 (selects 0x60 to 0x7C) store `wr_data[2:0]` as the stereo position of channel (code+7) mod 8, so select 0x60 sets channel 7 and select 0x64 sets channel 0.
- R8: Code 48 (select 0xC0) stores `wr_data[6:0]` as the sound frequency.
- R9: Code 56 (select 0xE0) stores `wr_data[23:0]` as the control word, and `pix_rate_o` then equals its bits [1:0].
- R10: A write with any other code (20-23, 49-55, 57-63) leaves every stored value unchanged and drives `wr_err_o` high for exactly the one cycle after the write.
- R11: In a cycle with `wr_en` low, no stored value changes and `wr_err_o` is low in the following cycle.
- R12: A write takes effect on the clock edge that samples it. The new value appears on the outputs in the cycle after the strobe and is not visible while the strobe is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| wr_data | input | 32 | Register code in [31:26], value in the low bits |
| pal_o | output | 208 | Palette entries, entry i in bits [13i+12:13i] |
| border_o | output | 13 | Border colour |
| cursor_o | output | 39 | Cursor colours, colour i in bits [13i+12:13i] |
| htim_o | output | 80 | Horizontal timing slots, slot i in bits [10i+9:10i] |
| vtim_o | output | 80 | Vertical timing slots, slot i in bits [10i+9:10i] |
| pan_o | output | 24 | Stereo positions, channel i in bits [3i+2:3i] |
| freq_o | output | 7 | Sound frequency |
| ctrl_o | output | 24 | Control word |
| pix_rate_o | output | 2 | Pixel-rate field of the control word |
| wr_err_o | output | 1 | One-cycle pulse after a write to an unknown code |

## Verification
Every result of this block is due one clock edge after its stimulus. This covers a stored value, a reset value and the error pulse alike. A behavioural model in the bench updates on the same edge the design samples, and all outputs are compared against it at the following falling edge, before the next input is driven. A directed check also samples an output in the same half-cycle its write is driven, to confirm that the old value is still shown. The reset check is taken at the first falling edge after the reset edge.

// File: rtl/vctl_pkg.sv
package vctl_pkg;

    localparam int CODE_W = 6;
    localparam int IDX_W  = 4;

    typedef enum logic [3:0] {
        TGT_NONE,
        TGT_PAL,
        TGT_BORDER,
        TGT_CURSOR,
        TGT_STEREO,
        TGT_HTIM,
        TGT_VTIM,
        TGT_FREQ,
        TGT_CTRL
    } tgt_e;

    typedef struct packed {
        tgt_e             tgt;
        logic [IDX_W-1:0] idx;
    } dec_t;

endpackage

// File: rtl/vctl_decode.sv
module vctl_decode
    import vctl_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output dec_t              dec
);

    always_comb begin
        dec.tgt = TGT_NONE;
        dec.idx = '0;
        if (code[5:4] == 2'b00) begin
            dec.tgt = TGT_PAL;
            dec.idx = code[3:0];
        end else if (code == 6'd16) begin
            dec.tgt = TGT_BORDER;
        end else if (code >= 6'd17 && code <= 6'd19) begin
            dec.tgt = TGT_CURSOR;
            dec.idx = IDX_W'(code - 6'd17);
        end else if (code[5:3] == 3'b011) begin
            // channel number is the slot number rotated back by one
            dec.tgt = TGT_STEREO;
            dec.idx = {1'b0, code[2:0] + 3'd7};
        end else if (code[5:3] == 3'b100) begin
            dec.tgt = TGT_HTIM;
            dec.idx = {1'b0, code[2:0]};
        end else if (code[5:3] == 3'b101) begin
            dec.tgt = TGT_VTIM;
            dec.idx = {1'b0, code[2:0]};
        end else if (code == 6'd48) begin
            dec.tgt = TGT_FREQ;
        end else if (code == 6'd56) begin
            dec.tgt = TGT_CTRL;
        end
    end

endmodule

// File: rtl/vctl_fields.sv
module vctl_fields #(
    parameter int COL_W  = 13,
    parameter int TIM_W  = 10,
    parameter int TIM_LO = 14,
    parameter int PAN_W  = 3,
    parameter int FREQ_W = 7,
    parameter int CTRL_W = 24
) (
    input  logic [31:0]       data,
    output logic [COL_W-1:0]  colour,
    output logic [TIM_W-1:0]  timing,
    output logic [PAN_W-1:0]  pan,
    output logic [FREQ_W-1:0] freq,
    output logic [CTRL_W-1:0] ctrl
);

    assign colour = data[COL_W-1:0];
    assign timing = data[TIM_LO +: TIM_W];
    assign pan    = data[PAN_W-1:0];
    assign freq   = data[FREQ_W-1:0];
    assign ctrl   = data[CTRL_W-1:0];

endmodule

// File: rtl/vctl_regbank.sv
module vctl_regbank
    import vctl_pkg::*;
#(
    parameter int N_PAL  = 16,
    parameter int N_CUR  = 3,
    parameter int N_TIM  = 8,
    parameter int N_CH   = 8,
    parameter int COL_W  = 13,
    parameter int TIM_W  = 10,
    parameter int PAN_W  = 3,
    parameter int FREQ_W = 7,
    parameter int CTRL_W = 24
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [31:0]               wr_data,
    output logic [N_PAL*COL_W-1:0]    pal_o,
    output logic [COL_W-1:0]          border_o,
    output logic [N_CUR*COL_W-1:0]    cursor_o,
    output logic [N_TIM*TIM_W-1:0]    htim_o,
    output logic [N_TIM*TIM_W-1:0]    vtim_o,
    output logic [N_CH*PAN_W-1:0]     pan_o,
    output logic [FREQ_W-1:0]         freq_o,
    output logic [CTRL_W-1:0]         ctrl_o,
    output logic [1:0]                pix_rate_o,
    output logic                      wr_err_o
);

    localparam int PAL_IW = $clog2(N_PAL);
    localparam int CUR_IW = $clog2(N_CUR);
    localparam int TIM_IW = $clog2(N_TIM);
    localparam int CH_IW  = $clog2(N_CH);
    localparam logic [1:0] RATE_FAST = 2'b11;

    typedef struct packed {
        logic [N_PAL-1:0][COL_W-1:0] pal;
        logic [COL_W-1:0]            border;
        logic [N_CUR-1:0][COL_W-1:0] cur;
        logic [N_TIM-1:0][TIM_W-1:0] htim;
        logic [N_TIM-1:0][TIM_W-1:0] vtim;
        logic [N_CH-1:0][PAN_W-1:0]  pan;
        logic [FREQ_W-1:0]           freq;
        logic [CTRL_W-1:0]           ctrl;
        logic                        err;
    } st_t;

    st_t st_d, st_q;
    dec_t dec;

    logic [COL_W-1:0]  f_colour;
    logic [TIM_W-1:0]  f_timing;
    logic [PAN_W-1:0]  f_pan;
    logic [FREQ_W-1:0] f_freq;
    logic [CTRL_W-1:0] f_ctrl;

    vctl_decode u_decode (
        .code (wr_data[31:26]),
        .dec  (dec)
    );

    vctl_fields #(
        .COL_W  (COL_W),
        .TIM_W  (TIM_W),
        .TIM_LO (14),
        .PAN_W  (PAN_W),
        .FREQ_W (FREQ_W),
        .CTRL_W (CTRL_W)
    ) u_fields (
        .data   (wr_data),
        .colour (f_colour),
        .timing (f_timing),
        .pan    (f_pan),
        .freq   (f_freq),
        .ctrl   (f_ctrl)
    );

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (wr_en) begin
            case (dec.tgt)
                TGT_PAL:    st_d.pal[dec.idx[PAL_IW-1:0]]  = f_colour;
                TGT_BORDER: st_d.border                    = f_colour;
                TGT_CURSOR: st_d.cur[dec.idx[CUR_IW-1:0]]  = f_colour;
                TGT_STEREO: st_d.pan[dec.idx[CH_IW-1:0]]   = f_pan;
                TGT_HTIM:   st_d.htim[dec.idx[TIM_IW-1:0]] = f_timing;
                TGT_VTIM:   st_d.vtim[dec.idx[TIM_IW-1:0]] = f_timing;
                TGT_FREQ:   st_d.freq                      = f_freq;
                TGT_CTRL:   st_d.ctrl                      = f_ctrl;
                default:    st_d.err                       = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q           <= '0;
            st_q.ctrl[1:0] <= RATE_FAST;
        end else begin
            st_q <= st_d;
        end
    end

    assign pal_o      = st_q.pal;
    assign border_o   = st_q.border;
    assign cursor_o   = st_q.cur;
    assign htim_o     = st_q.htim;
    assign vtim_o     = st_q.vtim;
    assign pan_o      = st_q.pan;
    assign freq_o     = st_q.freq;
    assign ctrl_o     = st_q.ctrl;
    assign pix_rate_o = st_q.ctrl[1:0];
    assign wr_err_o   = st_q.err;

endmodule

// File: rtl/vctl_regbank_chk.sv
module vctl_regbank_chk #(
    parameter int N_PAL  = 16,
    parameter int N_CUR  = 3,
    parameter int N_TIM  = 8,
    parameter int N_CH   = 8,
    parameter int COL_W  = 13,
    parameter int TIM_W  = 10,
    parameter int PAN_W  = 3,
    parameter int FREQ_W = 7,
    parameter int CTRL_W = 24
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   wr_en,
    input logic [31:0]            wr_data,
    input logic [N_PAL*COL_W-1:0] pal_o,
    input logic [COL_W-1:0]       border_o,
    input logic [N_CUR*COL_W-1:0] cursor_o,
    input logic [N_TIM*TIM_W-1:0] htim_o,
    input logic [N_TIM*TIM_W-1:0] vtim_o,
    input logic [N_CH*PAN_W-1:0]  pan_o,
    input logic [FREQ_W-1:0]      freq_o,
    input logic [CTRL_W-1:0]      ctrl_o,
    input logic [1:0]             pix_rate_o,
    input logic                   wr_err_o
);

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pix_rate_o == 2'b11 && border_o == '0 && freq_o == '0 && !wr_err_o));

    p_border_write_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && !$past(rst) && $past(wr_data[31:26]) == 6'd16)
        |-> border_o == $past(wr_data[COL_W-1:0]));

    p_freq_write_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && !$past(rst) && $past(wr_data[31:26]) == 6'd48)
        |-> freq_o == $past(wr_data[FREQ_W-1:0]));

    p_rate_write_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && !$past(rst) && $past(wr_data[31:26]) == 6'd56)
        |-> pix_rate_o == $past(wr_data[1:0]));

    p_err_cause_r10: assert property (@(posedge clk) disable iff (rst)
        wr_err_o |-> $past(wr_en));

    p_err_no_change_r10: assert property (@(posedge clk) disable iff (rst)
        wr_err_o |-> ($stable(pal_o) && $stable(border_o) && $stable(cursor_o) &&
                      $stable(htim_o) && $stable(vtim_o) && $stable(pan_o) &&
                      $stable(freq_o) && $stable(ctrl_o)));

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en) |-> (!wr_err_o && $stable(pal_o) && $stable(border_o) &&
                           $stable(cursor_o) && $stable(htim_o) && $stable(vtim_o) &&
                           $stable(pan_o) && $stable(freq_o) && $stable(ctrl_o)));

endmodule

bind vctl_regbank vctl_regbank_chk #(
    .N_PAL  (N_PAL),
    .N_CUR  (N_CUR),
    .N_TIM  (N_TIM),
    .N_CH   (N_CH),
    .COL_W  (COL_W),
    .TIM_W  (TIM_W),
    .PAN_W  (PAN_W),
    .FREQ_W (FREQ_W),
    .CTRL_W (CTRL_W)
) u_chk (.*);

// File: tb/vctl_regbank_tb.sv
`timescale 1ns/1ps
module vctl_regbank_tb;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [31:0]  wr_data = '0;
    logic [207:0] pal_o;
    logic [12:0]  border_o;
    logic [38:0]  cursor_o;
    logic [79:0]  htim_o;
    logic [79:0]  vtim_o;
    logic [23:0]  pan_o;
    logic [6:0]   freq_o;
    logic [23:0]  ctrl_o;
    logic [1:0]   pix_rate_o;
    logic         wr_err_o;

    int checks = 0;
    int errors = 0;

    // reference model state
    int m_pal[16];
    int m_border;
    int m_cur[3];
    int m_h[8];
    int m_v[8];
    int m_pan[8];
    int m_freq;
    int m_ctrl;
    int m_err;

    always #2.5 clk = ~clk;

    vctl_regbank u_dut (
        .clk (clk), .rst (rst), .wr_en (wr_en), .wr_data (wr_data),
        .pal_o (pal_o), .border_o (border_o), .cursor_o (cursor_o),
        .htim_o (htim_o), .vtim_o (vtim_o), .pan_o (pan_o),
        .freq_o (freq_o), .ctrl_o (ctrl_o), .pix_rate_o (pix_rate_o),
        .wr_err_o (wr_err_o)
    );

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_pal[i]) m_pal[i] = 0;
            foreach (m_cur[i]) m_cur[i] = 0;
            foreach (m_h[i])   m_h[i] = 0;
            foreach (m_v[i])   m_v[i] = 0;
            foreach (m_pan[i]) m_pan[i] = 0;
            m_border = 0; m_freq = 0; m_ctrl = 3; m_err = 0;
        end else begin
            m_err = 0;
            if (wr_en) begin
                int code;
                code = int'(wr_data[31:26]);
                if (code < 16)                    m_pal[code] = int'(wr_data[12:0]);
                else if (code == 16)              m_border = int'(wr_data[12:0]);
                else if (code >= 17 && code <= 19) m_cur[code-17] = int'(wr_data[12:0]);
                else if (code >= 24 && code <= 31) m_pan[(code+7)%8] = int'(wr_data[2:0]);
                else if (code >= 32 && code <= 39) m_h[code-32] = int'(wr_data[23:14]);
                else if (code >= 40 && code <= 47) m_v[code-40] = int'(wr_data[23:14]);
                else if (code == 48)              m_freq = int'(wr_data[6:0]);
                else if (code == 56)              m_ctrl = int'(wr_data[23:0]);
                else                              m_err = 1;
            end
        end
    end

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        for (int i = 0; i < 16; i++) chk("R3", $sformatf("palette %0d", i), int'(pal_o[i*13 +: 13]), m_pal[i]);
        chk("R4", "border", int'(border_o), m_border);
        for (int i = 0; i < 3; i++) chk("R4", $sformatf("cursor %0d", i), int'(cursor_o[i*13 +: 13]), m_cur[i]);
        for (int i = 0; i < 8; i++) chk("R5", $sformatf("htim %0d", i), int'(htim_o[i*10 +: 10]), m_h[i]);
        for (int i = 0; i < 8; i++) chk("R6", $sformatf("vtim %0d", i), int'(vtim_o[i*10 +: 10]), m_v[i]);
        for (int i = 0; i < 8; i++) chk("R7", $sformatf("stereo ch %0d", i), int'(pan_o[i*3 +: 3]), m_pan[i]);
        chk("R8", "frequency", int'(freq_o), m_freq);
        chk("R9", "control", int'(ctrl_o), m_ctrl);
        chk("R9", "pixel rate", int'(pix_rate_o), m_ctrl & 3);
        chk("R10", "error pulse", int'(wr_err_o), m_err);
    endtask

    // one write at a falling edge; outputs compared at the next falling edge
    task automatic step(logic en, logic [31:0] d);
        @(negedge clk);
        compare_all();
        wr_en   = en;
        wr_data = d;
    endtask

    task automatic check_reset_state();
        chk("R1", "pixel rate after reset", int'(pix_rate_o), 3);
        chk("R1", "control after reset", int'(ctrl_o), 3);
        chk("R1", "palette after reset", int'(|pal_o), 0);
        chk("R1", "timing after reset", int'(|{htim_o, vtim_o}), 0);
        chk("R1", "others after reset", int'(|{border_o, cursor_o, pan_o, freq_o, wr_err_o}), 0);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [23:0] snap_ctrl;
        logic [207:0] snap_pal;
        repeat (3) @(negedge clk);
        check_reset_state();
        rst = 1'b0;

        // every code once, with bits [25:24] varied
        for (int c = 0; c < 64; c++) step(1'b1, {c[5:0], c[1:0], 24'h000000 | 24'($urandom)});
        step(1'b0, '0);

        // R2: bits [25:24] ignored; R12: old value still shown during the strobe
        step(1'b1, {6'd16, 2'b00, 11'd0, 13'h0155});
        step(1'b0, '0);
        @(negedge clk);
        compare_all();
        wr_en = 1'b1;
        wr_data = {6'd16, 2'b11, 11'd0, 13'h1abc};
        #1;
        chk("R12", "border during strobe", int'(border_o), 13'h0155);
        @(negedge clk);
        chk("R2", "border via select 0x43", int'(border_o), 13'h1abc);
        chk("R12", "border one cycle later", int'(border_o), 13'h1abc);
        wr_en = 1'b0;

        // R7: slot 0x60 lands on channel 7, slot 0x64 on channel 0
        step(1'b1, {6'd24, 26'd5});
        step(1'b1, {6'd25, 26'd3});
        step(1'b0, '0);
        @(negedge clk);
        chk("R7", "select 0x60 -> channel 7", int'(pan_o[21 +: 3]), 5);
        chk("R7", "select 0x64 -> channel 0", int'(pan_o[0 +: 3]), 3);

        // R10: unknown code, R11: idle cycles
        snap_ctrl = ctrl_o;
        snap_pal  = pal_o;
        step(1'b1, {6'd57, 26'h3ffffff});
        step(1'b0, '0);
        chk("R10", "error pulse after unknown code", int'(wr_err_o), 1);
        repeat (4) step(1'b0, 32'hffffffff);
        chk("R11", "control held while idle", int'(ctrl_o), int'(snap_ctrl));
        chk("R11", "palette held while idle", int'(pal_o == snap_pal), 1);
        chk("R11", "no error while idle", int'(wr_err_o), 0);

        // random traffic
        for (int n = 0; n < 2500; n++) step(1'($urandom_range(0, 3) != 0), $urandom);

        // reset mid-run
        @(negedge clk);
        compare_all();
        wr_en = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check_reset_state();
        rst = 1'b0;
        for (int n = 0; n < 200; n++) step(1'b1, $urandom);
        step(1'b0, '0);
        @(negedge clk);
        compare_all();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule